// File: doc/BRIEF.md
# Parallel Configuration Byte Loader

This controller sits on the host side of an FPGA configuration port that takes one byte per write. It accepts the configuration image as a valid/ready byte stream and turns it into writes toward the target. Each load follows a fixed order. The loader first drives the target's program pin low for a fixed time. It then waits until the target's INIT pin reports that the configuration memory has been cleared. After INIT rises it waits a further guard time before the first byte. From there it writes the bytes one at a time, and before each next byte it waits for the target's ready/busy pin to show that the previous byte has been taken in.

The loader treats INIT going low after the clear as a configuration error. It stops writing at once and holds a sticky error flag. It does not wait for the target's serial clock to stop, because that clock keeps running after an error. If INIT never rises after the program pulse, a watchdog ends the wait and sets a separate timeout flag. INIT and RDY/BUSY come from another device, so both pass through two-stage synchronizers before they are used.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is held, and after reset until a start, `prog_n`, `cs_n` and `wr_n` are high, and `in_ready`, `busy`, `done`, `err` and `tmo` are low.
- R2: A `start` pulse taken while the loader is idle, done or in error drives `prog_n` low for exactly `PROG_LOW_CYC` clock cycles.
- R3: After the program pulse, no write strobe is issued and `in_ready` stays low until INIT has first been seen low and then high. A high RDY/BUSY during the memory clear does not count as permission to write.
- R4: The first write strobe of a load falls at least `SETTLE_CYC` cycles after the INIT pin rises.
- R5: A write strobe starts only while RDY/BUSY is high. After each byte the loader waits for RDY/BUSY to come back high before it accepts the next byte.
- R6: `wr_n` stays low for exactly `STROBE_CYC` cycles. `cs_n` is low from one cycle before the strobe until one cycle after it. `cfg_d` holds the same value over that whole window.
- R7: Bytes are taken from the stream only on cycles where `in_valid` and `in_ready` are both high. They are written in arrival order, and exactly `byte_total` of them are written per load.
- R8: `done` rises only after the last byte has been absorbed (RDY/BUSY high again) and stays high until the next start. When `byte_total` is 0, `done` rises after the settle delay and no write is made.
- R9: If INIT falls during the settle delay or while loading, the loader makes no further handshakes or strobes, raises a sticky `err` and never raises `done`. This also holds when the INIT fall and the RDY/BUSY return reach the loader in the same cycle: the pending byte is not accepted.
- R10: If INIT has not risen `INIT_TMO_CYC` cycles after `prog_n` is released, `tmo` and `err` are both set. No write takes place in that load.
- R11: A `start` pulse during a load has no effect. A `start` from done or error clears `done`, `err` and `tmo` and runs a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (pulse) |
| byte_total | input | CNT_W | Number of bytes to write, captured at start |
| in_data | input | DATA_W | Stream byte |
| in_valid | input | 1 | Stream byte is present |
| in_ready | output | 1 | Loader takes the byte on this cycle |
| prog_n | output | 1 | Target program pin, active low |
| cs_n | output | 1 | Target chip select, active low |
| wr_n | output | 1 | Target write strobe, active low |
| cfg_d | output | DATA_W | Byte presented to the target |
| tgt_init | input | 1 | Target INIT pin (high: cleared and healthy) |
| tgt_rdy | input | 1 | Target RDY/BUSY pin (high: ready) |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed, sticky |
| err | output | 1 | INIT dropped or timed out, sticky |
| tmo | output | 1 | INIT did not rise in time, sticky |

## Verification
The case that needs the most care is when the target's ready signal comes back and its INIT fails in the same cycle. From the loader's side, the byte it is about to accept and the error it must honour arrive together. The bench sets this up with a target model that drops INIT at the very moment it releases RDY/BUSY after byte three of eight, so both synchronizers change on the same edge. The result is judged at the ports: the stream must show exactly three bytes consumed, the target must have captured exactly three, and `in_ready` and `wr_n` must stay quiet afterwards while `err` holds.

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int PROG_LOW_CYC = 50,
  parameter int SETTLE_CYC   = 300,
  parameter int STROBE_CYC   = 2,
  parameter int INIT_TMO_CYC = 1000000,
  parameter int CNT_W        = 24,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_total,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              prog_n,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] cfg_d,
  input  logic              tgt_init,
  input  logic              tgt_rdy,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tmo
);

  localparam int TA   = PROG_LOW_CYC > SETTLE_CYC ? PROG_LOW_CYC : SETTLE_CYC;
  localparam int TB   = STROBE_CYC > INIT_TMO_CYC ? STROBE_CYC : INIT_TMO_CYC;
  localparam int TMAX = TA > TB ? TA : TB;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WINIT, S_SETTLE, S_WRITE,
    S_SETUP, S_STROBE, S_HOLD, S_WRDY, S_DONE, S_ERR
  } st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [CNT_W-1:0]  cnt, total_r;
  logic [DATA_W-1:0] dreg;
  logic [1:0]        init_q, rdy_q;
  logic              seen_low, err_r, tmo_r;
  logic              init_s, rdy_s, last_byte;

  assign init_s    = init_q[1];
  assign rdy_s     = rdy_q[1];
  assign last_byte = (cnt == total_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 2'b00;
      rdy_q  <= 2'b00;
    end else begin
      init_q <= {init_q[0], tgt_init};
      rdy_q  <= {rdy_q[0], tgt_rdy};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      cnt      <= '0;
      total_r  <= '0;
      dreg     <= '0;
      seen_low <= 1'b0;
      err_r    <= 1'b0;
      tmo_r    <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: begin
          if (start) begin
            st       <= S_PROG;
            tmr      <= '0;
            cnt      <= '0;
            total_r  <= byte_total;
            seen_low <= 1'b0;
            err_r    <= 1'b0;
            tmo_r    <= 1'b0;
          end
        end
        S_PROG: begin
          if (!init_s) seen_low <= 1'b1;
          if (tmr == TW'(PROG_LOW_CYC - 1)) begin
            st  <= S_WINIT;
            tmr <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_WINIT: begin
          if (!init_s) seen_low <= 1'b1;
          if (init_s && seen_low) begin
            st  <= S_SETTLE;
            tmr <= '0;
          end else if (tmr == TW'(INIT_TMO_CYC - 1)) begin
            st    <= S_ERR;
            err_r <= 1'b1;
            tmo_r <= 1'b1;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: begin
          if (!init_s) begin
            st    <= S_ERR;
            err_r <= 1'b1;
          end else begin
            case (st)
              S_SETTLE: begin
                if (tmr == TW'(SETTLE_CYC - 1)) st <= last_byte ? S_DONE : S_WRITE;
                else tmr <= tmr + TW'(1);
              end
              S_WRITE: begin
                if (in_valid && in_ready) begin
                  dreg <= in_data;
                  st   <= S_SETUP;
                end
              end
              S_SETUP: begin
                st  <= S_STROBE;
                tmr <= '0;
              end
              S_STROBE: begin
                if (tmr == TW'(STROBE_CYC - 1)) st <= S_HOLD;
                else tmr <= tmr + TW'(1);
              end
              S_HOLD: begin
                cnt <= cnt + CNT_W'(1);
                st  <= S_WRDY;
              end
              S_WRDY: begin
                if (rdy_s) st <= last_byte ? S_DONE : S_WRITE;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign in_ready = (st == S_WRITE) && rdy_s && init_s;
  assign prog_n   = (st != S_PROG);
  assign wr_n     = (st != S_STROBE);
  assign cs_n     = !((st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD));
  assign cfg_d    = dreg;
  assign busy     = !((st == S_IDLE) || (st == S_DONE) || (st == S_ERR));
  assign done     = (st == S_DONE);
  assign err      = err_r;
  assign tmo      = tmo_r;

endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
  parameter int PROG_LOW_CYC = 50,
  parameter int STROBE_CYC   = 2,
  parameter int DATA_W       = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic              prog_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] cfg_d,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              tmo
);

  int plow, wlow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plow <= 0;
      wlow <= 0;
    end else begin
      plow <= prog_n ? 0 : plow + 1;
      wlow <= wr_n ? 0 : wlow + 1;
    end
  end

  AST_PROG_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> plow == PROG_LOW_CYC); // R2
  AST_QUIET_DURING_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (wr_n && cs_n && !in_ready)); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wlow == STROBE_CYC) || err); // R6
  AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n); // R6
  AST_DATA_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || $rose(wr_n)) |-> $stable(cfg_d)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err); // R9
  AST_TMO_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> err); // R10
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_n && start) |=> prog_n); // R11

endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(
  .PROG_LOW_CYC(PROG_LOW_CYC),
  .STROBE_CYC  (STROBE_CYC),
  .DATA_W      (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .in_ready(in_ready),
  .prog_n  (prog_n),
  .cs_n    (cs_n),
  .wr_n    (wr_n),
  .cfg_d   (cfg_d),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .tmo     (tmo)
);

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;
  localparam int P_PROG = 5;
  localparam int P_SET  = 12;
  localparam int P_STB  = 2;
  localparam int P_TMO  = 200;
  localparam int CW     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [CW-1:0] byte_total = '0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          prog_n, cs_n, wr_n;
  logic [7:0]    cfg_d;
  logic          tgt_init = 1'b0;
  logic          tgt_rdy = 1'b1;
  logic          busy, done, err, tmo;

  cfg_byte_loader #(
    .PROG_LOW_CYC(P_PROG), .SETTLE_CYC(P_SET), .STROBE_CYC(P_STB),
    .INIT_TMO_CYC(P_TMO), .CNT_W(CW), .DATA_W(8)
  ) u_cfg_byte_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .prog_n(prog_n), .cs_n(cs_n), .wr_n(wr_n), .cfg_d(cfg_d),
    .tgt_init(tgt_init), .tgt_rdy(tgt_rdy),
    .busy(busy), .done(done), .err(err), .tmo(tmo)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_total = 0, m_clear = 4, m_busy = 1, m_gap = 0, m_erra = -1, m_kset = -1, m_seed = 0;
  bit m_never = 1'b0, src_en = 1'b0;
  logic [7:0] cap [0:255];
  int cap_n = 0, src_idx = 0, prog_falls = 0, wr_falls = 0, tw = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 53 + m_seed * 17 + 9);
  endfunction

  // watchdog
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cyc >= 150000) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // target model
  initial begin
    int clr, bc, sc;
    bit inwr, up, killed;
    clr = 0; bc = 0; sc = 0; inwr = 0; up = 0; killed = 0;
    forever begin
      @(negedge clk);
      #2;
      if (!prog_n) begin
        tgt_init = 1'b0; tgt_rdy = 1'b1;
        clr = 0; up = 0; killed = 0; inwr = 0; bc = 0;
      end else begin
        if (!up && !killed && !m_never) begin
          clr++;
          if (clr >= m_clear) begin up = 1; tgt_init = 1'b1; sc = 0; end
        end else if (up && m_kset >= 0) begin
          sc++;
          if (sc == m_kset) begin tgt_init = 1'b0; killed = 1; up = 0; end
        end
        if (!wr_n) begin
          tgt_rdy = 1'b0; inwr = 1;
        end else if (inwr) begin
          inwr = 0; cap[cap_n] = cfg_d; cap_n++; bc = m_busy;
          if (bc == 0) begin
            tgt_rdy = 1'b1;
            if (cap_n == m_erra) begin tgt_init = 1'b0; killed = 1; up = 0; end
          end
        end else if (!tgt_rdy) begin
          bc--;
          if (bc <= 0) begin
            tgt_rdy = 1'b1;
            if (cap_n == m_erra) begin tgt_init = 1'b0; killed = 1; up = 0; end
          end
        end
      end
    end
  end

  // stream source
  initial begin
    bit hs;
    hs = 0;
    forever begin
      @(negedge clk);
      if (hs) src_idx++;
      if (!src_en || src_idx >= m_total) in_valid = 1'b0;
      else if (in_valid && !hs) in_valid = 1'b1;
      else in_valid = (m_gap == 0) || ((cyc % 3) != 1);
      in_data = pat(src_idx);
      hs = in_valid && in_ready;
    end
  end

  // pin monitor
  initial begin
    int pl, ih, wl;
    bit pp, pwr, pcs, pdone, first, tw_run;
    logic [7:0] pd;
    pl = 0; ih = 0; wl = 0; pp = 1; pwr = 1; pcs = 1; pdone = 0; first = 0; tw_run = 0; pd = '0;
    forever begin
      @(negedge clk);
      if (!prog_n) begin
        if (pp) prog_falls++;
        pl++;
      end else if (!pp) begin
        chk(pl == P_PROG, "R2 program pulse width", pl, P_PROG);
        pl = 0; tw = 1; tw_run = 1; first = 1;
      end else if (tw_run) begin
        if (tmo) tw_run = 0; else tw++;
      end
      if (tgt_init) ih++; else ih = 0;
      if (!wr_n && pwr) begin
        wr_falls++;
        chk(!pcs && cfg_d == pd, "R6 select and data one cycle before strobe", int'(cfg_d), int'(pd));
        chk(tgt_init == 1'b1, "R3 strobe only after INIT high", int'(tgt_init), 1);
        chk(tgt_rdy == 1'b1, "R5 strobe only while RDY high", int'(tgt_rdy), 1);
        if (first) begin
          chk(ih > P_SET, "R4 settle delay before first strobe", ih, P_SET + 1);
          first = 0;
        end
        wl = 1;
      end else if (!wr_n) begin
        wl++;
      end else if (!pwr) begin
        chk(wl == P_STB, "R6 strobe width", wl, P_STB);
        chk(!cs_n && cfg_d == pd, "R6 select and data one cycle after strobe", int'(cfg_d), int'(pd));
      end
      if (done && !pdone)
        chk(cap_n == m_total && tgt_rdy, "R8 done only after last byte absorbed", cap_n, m_total);
      pp = prog_n; pwr = wr_n; pcs = cs_n; pd = cfg_d; pdone = done;
    end
  end

  task automatic run(input int total, input int clear, input int bsy, input int gap,
                     input int erra, input int kset, input bit never, input bit poke, input int seed);
    int lim;
    bit poked;
    src_en = 0;
    m_total = total; m_clear = clear; m_busy = bsy; m_gap = gap;
    m_erra = erra; m_kset = kset; m_never = never; m_seed = seed;
    byte_total = CW'(total);
    @(negedge clk);
    cap_n = 0; src_idx = 0; prog_falls = 0; wr_falls = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; src_en = 1;
    lim = 0; poked = 0;
    while (!(done || err) && lim < 3000) begin
      @(negedge clk);
      lim++;
      if (poke && !poked && wr_falls == 1) begin start = 1'b1; poked = 1; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk(lim < 3000, "R8 load reaches an end state", lim, 3000);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input int total);
    int bad_i;
    bad_i = -1;
    for (int i = total - 1; i >= 0; i--) if (cap[i] != pat(i)) bad_i = i;
    chk(cap_n == total, req, cap_n, total);
    if (bad_i >= 0) chk(1'b0, req, int'(cap[bad_i]), int'(pat(bad_i)));
    else chk(1'b1, req, 0, 0);
  endtask

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    chk({prog_n, cs_n, wr_n} == 3'b111 && {in_ready, busy, done, err, tmo} == 5'b0,
        "R1 outputs in reset", int'({prog_n, cs_n, wr_n, in_ready, busy, done, err, tmo}), 8'hE0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({prog_n, cs_n, wr_n} == 3'b111 && {in_ready, busy, done, err, tmo} == 5'b0,
        "R1 outputs idle after reset", int'({prog_n, cs_n, wr_n, in_ready, busy, done, err, tmo}), 8'hE0);

    // sweep: busy time x length x stream gaps
    for (int b = 0; b < 4; b++)
      for (int n = 1; n <= 4; n++)
        for (int g = 0; g < 2; g++) begin
          seed++;
          run(n, 3 + b * 5, b, g, -1, -1, 0, 0, seed);
          chk(done && !err && !tmo, "R8 done after full load", int'({done, err, tmo}), 4);
          chk(prog_falls == 1, "R2 one program pulse per load", prog_falls, 1);
          check_bytes("R7 bytes written in stream order", n);
        end

    // long clear with RDY falsely ready
    seed++;
    run(3, 60, 2, 0, -1, -1, 0, 0, seed);
    chk(done && !err, "R3 load after long clear completes", int'({done, err}), 2);
    check_bytes("R3 R7 bytes after long clear", 3);

    // empty image
    seed++;
    run(0, 5, 1, 0, -1, -1, 0, 0, seed);
    chk(done && !err && wr_falls == 0, "R8 zero-length load", wr_falls, 0);

    // start during load ignored
    seed++;
    run(6, 8, 2, 0, -1, -1, 0, 1, seed);
    chk(prog_falls == 1, "R11 start ignored while busy", prog_falls, 1);
    check_bytes("R11 load unaffected by extra start", 6);

    // INIT lost during settle
    seed++;
    run(5, 8, 1, 0, -1, 4, 0, 0, seed);
    chk(err && !done && !tmo, "R9 error during settle", int'({err, done, tmo}), 4);
    chk(wr_falls == 0 && cap_n == 0, "R9 no write after settle error", wr_falls, 0);

    // INIT lost exactly as RDY returns after byte 3
    seed++;
    run(8, 8, 3, 1, 3, -1, 0, 0, seed);
    chk(err && !done, "R9 error on coincident INIT loss", int'({err, done}), 2);
    chk(cap_n == 3, "R9 bytes captured before error", cap_n, 3);
    chk(src_idx == 3, "R9 pending byte not accepted", src_idx, 3);
    repeat (20) @(negedge clk);
    chk(!in_ready && wr_falls == 3 && err, "R9 quiet and sticky after error", wr_falls, 3);

    // INIT never rises
    seed++;
    run(4, 8, 1, 0, -1, -1, 1, 0, seed);
    chk(tmo && err && !done, "R10 timeout flags", int'({tmo, err, done}), 6);
    chk(tw == P_TMO, "R10 timeout delay", tw, P_TMO);
    chk(wr_falls == 0, "R10 no write on timeout", wr_falls, 0);

    // restart clears flags
    seed++;
    run(5, 6, 2, 1, -1, -1, 0, 0, seed);
    chk(done && !err && !tmo, "R11 restart clears flags", int'({done, err, tmo}), 4);
    check_bytes("R11 bytes after restart", 5);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule